// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write a 2K x 8 asynchronous static RAM. The system side raises a request strobe for one cycle with a read/write select, an address and, for a write, a data byte. The controller then runs the RAM's control pins through a fixed series of phases and pulses `done` when the access is complete. For a read, the byte captured from the RAM is presented on `rdata` in that same cycle.

Each phase lasts a whole number of clock cycles. The controller derives these counts from RAM timing limits, which are given as parameters in nanoseconds, and from the clock period. A write has three phases: address setup, the low write pulse, and data and address hold. A read has two: the access window, followed by a bus turnaround that gives the RAM time to stop driving the shared data lines. Because of the turnaround, a write that follows a read never fights the RAM's output drivers.

Only one access runs at a time. `busy` is high while an access is in flight, and any request made during that time is discarded.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1, and `busy` and `done` are 0.
- R2: Each phase length is the smallest whole number of clock periods that is at least its governing time. Setup is governed by the address setup time. The write pulse is governed by the largest of the pulse width, the address-valid-to-end time minus the setup time, and the data setup time. Hold is governed by the larger of the data hold and address hold times. The read access is governed by the larger of the address access and output-enable access times. The turnaround is governed by the output-disable time. Every phase is at least one cycle long.
- R3: A write accepted at a clock edge works as follows, counting the cycles after that edge. `mem_ce_n` is 0 for setup+pulse+hold cycles. `mem_we_n` is 0 only in cycles setup+1 through setup+pulse. `mem_oe_n` stays 1 throughout.
- R4: A read accepted at a clock edge drives `mem_ce_n` and `mem_oe_n` to 0 for the access length and keeps `mem_we_n` at 1. The value on `mem_dq` at the last edge of the access window becomes `rdata`.
- R5: After the access window of a read, `mem_oe_n` returns to 1 while `mem_ce_n` stays 0 for the turnaround length. Only then does the access end.
- R6: The controller drives `mem_dq` only while `mem_we_n` is 0 and during the hold phase that follows. At all other times the pins are released, so a read returns the RAM's value unaltered.
- R7: `busy` is 1 from the cycle after acceptance until the access ends. `done` is 1 for exactly one cycle, the first cycle in which `busy` is back at 0.
- R8: A request made while `busy` is 1 is ignored. It produces no extra access, and it does not change the address or data of the access in flight.
- R9: A byte written to any address is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, sampled when idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 11 | Access address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `done` is 1 after a read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access in progress |
| mem_addr | output | 11 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq | inout | 8 | RAM data bus |

## Verification
The bench checks the pin sequence of every access cycle by cycle against phase lengths that it derives itself by counting periods. A mis-rounded phase count would shorten the write pulse, and the RAM model would record a timing violation. The bench writes and reads back all 2048 addresses, and a missing turnaround would make a write collide with the RAM's output. A read sampled too early would capture the model's placeholder byte. A request injected mid-access is checked to leave both the target and the alternate address untouched, which catches a controller that restarts or relatches while busy.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WSET = 3'd1,
    PH_WPUL = 3'd2,
    PH_WHLD = 3'd3,
    PH_RACC = 3'd4,
    PH_RTRN = 3'd5
  } phase_e;

  // Round a nanosecond time up to whole clock periods, never below one.
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    return max2(max2(a, b), c);
  endfunction

endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int N_SET = 1,
  parameter int N_PUL = 6,
  parameter int N_HLD = 2,
  parameter int N_RD  = 9,
  parameter int N_TRN = 4,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic          zero,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          accept,
  output logic          sample,
  output logic          drv,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          busy,
  output logic          done
);
  phase_e st, nx;
  logic   phase_end;

  function automatic int phase_len(input phase_e p);
    case (p)
      PH_WSET: return N_SET;
      PH_WPUL: return N_PUL;
      PH_WHLD: return N_HLD;
      PH_RACC: return N_RD;
      PH_RTRN: return N_TRN;
      default: return 1;
    endcase
  endfunction

  assign accept    = (st == PH_IDLE) && req;
  assign phase_end = (st != PH_IDLE) && zero;
  assign sample    = (st == PH_RACC) && zero;

  always_comb begin
    nx = st;
    case (st)
      PH_IDLE: if (req)  nx = wr ? PH_WSET : PH_RACC;
      PH_WSET: if (zero) nx = PH_WPUL;
      PH_WPUL: if (zero) nx = PH_WHLD;
      PH_WHLD: if (zero) nx = PH_IDLE;
      PH_RACC: if (zero) nx = PH_RTRN;
      PH_RTRN: if (zero) nx = PH_IDLE;
      default: nx = PH_IDLE;
    endcase
  end

  assign load     = (nx != st) && (nx != PH_IDLE);
  assign load_val = CW'(phase_len(nx) - 1);

  // Pin controls are registered from the next phase so they change cleanly.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= PH_IDLE;
      ce_n <= 1'b1;
      oe_n <= 1'b1;
      we_n <= 1'b1;
      drv  <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      st   <= nx;
      ce_n <= (nx == PH_IDLE);
      oe_n <= (nx != PH_RACC);
      we_n <= (nx != PH_WPUL);
      drv  <= (nx == PH_WPUL) || (nx == PH_WHLD);
      busy <= (nx != PH_IDLE);
      done <= phase_end && ((st == PH_WHLD) || (st == PH_RTRN));
    end
  end

  p_we_oe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));
  p_we_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_sample_in_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (!oe_n && !ce_n));
  p_turn_oe_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) && busy |-> !ce_n);
endmodule

// File: rtl/asram_bus.sv
`timescale 1ns/1ps
module asram_bus #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          drv,
  input  logic          sample,
  input  logic          busy,
  input  logic          oe_n,
  output logic [AW-1:0] mem_addr,
  inout  wire  [DW-1:0] mem_dq,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0;
      wdata_q  <= '0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        mem_addr <= addr_in;
        wdata_q  <= wdata_in;
      end
      if (sample) rdata <= mem_dq;
    end
  end

  assign mem_dq = drv ? wdata_q : {DW{1'bz}};

  p_drive_oe_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> oe_n);
  p_addr_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mem_addr));
  p_data_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(wdata_q));
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW     = 11,
  parameter int DW     = 8,
  parameter int CLK_NS = 10,
  parameter int T_AS   = 10,
  parameter int T_WP   = 55,
  parameter int T_AW   = 70,
  parameter int T_DS   = 30,
  parameter int T_DH   = 20,
  parameter int T_AH   = 15,
  parameter int T_AA   = 90,
  parameter int T_OE   = 65,
  parameter int T_OHZ  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  inout  wire  [DW-1:0] mem_dq
);
  localparam int N_SET = ns2cyc(T_AS, CLK_NS);
  localparam int N_PUL = ns2cyc(max3(T_WP, T_AW - T_AS, T_DS), CLK_NS);
  localparam int N_HLD = ns2cyc(max2(T_DH, T_AH), CLK_NS);
  localparam int N_RD  = ns2cyc(max2(T_AA, T_OE), CLK_NS);
  localparam int N_TRN = ns2cyc(T_OHZ, CLK_NS);
  localparam int N_MAX = max2(max3(N_SET, N_PUL, N_HLD), max2(N_RD, N_TRN));
  localparam int CW    = $clog2(N_MAX + 1);

  logic          t_load, t_zero, accept, sample, drv;
  logic [CW-1:0] t_val;

  asram_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  asram_seq #(
    .N_SET(N_SET), .N_PUL(N_PUL), .N_HLD(N_HLD),
    .N_RD(N_RD), .N_TRN(N_TRN), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .zero(t_zero),
    .load(t_load), .load_val(t_val), .accept(accept), .sample(sample),
    .drv(drv), .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .busy(busy), .done(done)
  );

  asram_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .accept(accept), .addr_in(addr),
    .wdata_in(wdata), .drv(drv), .sample(sample), .busy(busy),
    .oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq(mem_dq), .rdata(rdata)
  );
endmodule

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_model (
  input  logic [10:0] a,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  inout  wire  [7:0]  dq
);
  logic [7:0] mem [2048];
  int      viol;
  realtime t_a, t_oe_fall, t_oe_rise, t_we_fall, t_we_rise, t_d, t_ce_fall;
  logic    ready, fall_seen;
  wire     rd_on = !ce_n && !oe_n && we_n;

  initial begin
    viol = 0; ready = 0; fall_seen = 0;
    t_a = 0; t_oe_fall = 0; t_oe_rise = -1000; t_we_fall = 0;
    t_we_rise = -1000; t_d = 0; t_ce_fall = 0;
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
  end

  assign dq = rd_on ? (ready ? mem[a] : 8'h3C) : 8'bz;

  always #1 ready = rd_on && ($realtime - t_a >= 90) && ($realtime - t_oe_fall >= 65);

  always @(a) begin
    if ($realtime - t_we_rise < 15) viol++;
    t_a = $realtime;
  end
  always @(negedge ce_n) t_ce_fall = $realtime;
  always @(negedge oe_n) t_oe_fall = $realtime;
  always @(posedge oe_n) t_oe_rise = $realtime;
  always @(negedge we_n) begin
    if ($realtime - t_a < 10) viol++;
    if ($realtime - t_oe_rise < 40) viol++;
    if (ce_n) viol++;
    t_we_fall = $realtime;
    fall_seen = 1;
  end
  always @(posedge we_n) begin
    if (fall_seen) begin
      if ($realtime - t_we_fall < 55) viol++;
      if ($realtime - ((t_ce_fall > t_we_fall) ? t_ce_fall : t_we_fall) < 55) viol++;
      if ($realtime - t_a < 70) viol++;
      if ($realtime - t_d < 30) viol++;
      if (!ce_n) mem[a] = dq;
      t_we_rise = $realtime;
      fall_seen = 0;
    end
  end
  always @(dq) begin
    if (we_n && ($realtime - t_we_rise < 20)) viol++;
    t_d = $realtime;
  end
endmodule

module asram_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, wr = 0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  wire  [7:0]  rdata;
  wire         done, busy, ce_n, oe_n, we_n;
  wire  [10:0] mem_addr;
  wire  [7:0]  dq;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  asram_ctrl #(.CLK_NS(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .busy(busy), .mem_addr(mem_addr),
    .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_dq(dq)
  );
  asram_model u_ram (.a(mem_addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .dq(dq));

  function automatic int periods(input int ns);
    int c = 1;
    while (c * 8 < ns) c++;
    return c;
  endfunction

  int S, P, H, RD, TR;
  initial begin
    S  = periods(10);
    P  = periods(70 - 10); if (periods(55) > P) P = periods(55);
    H  = periods(20);
    RD = periods(90);
    TR = periods(40);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int last_we_low, last_oe_low;

  task automatic xact(input bit w, input [10:0] a, input [7:0] d, input bit intr,
                      output [7:0] r);
    int tot, pe, wl, ol;
    tot = w ? (S + P + H) : (RD + TR);
    pe = 0; wl = 0; ol = 0;
    @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d;
    for (int k = 1; k <= tot + 1; k++) begin
      @(negedge clk);
      if (k == 1) req = 0;
      if (intr && k == 2) begin req = 1; wr = ~w; addr = ~a; wdata = ~d; end
      if (intr && k == 3) req = 0;
      if (!we_n) wl++;
      if (!oe_n) ol++;
      if (k <= tot) begin
        if (ce_n !== 1'b0 || busy !== 1'b1 || done !== 1'b0) pe++;
        if (w) begin
          if (oe_n !== 1'b1) pe++;
          if (we_n !== ((k > S && k <= S + P) ? 1'b0 : 1'b1)) pe++;
        end else begin
          if (we_n !== 1'b1) pe++;
          if (oe_n !== ((k <= RD) ? 1'b0 : 1'b1)) pe++;
        end
      end else begin
        if (done !== 1'b1 || busy !== 1'b0 || ce_n !== 1'b1) pe++;
        r = rdata;
      end
    end
    last_we_low = wl; last_oe_low = ol;
    chk(pe == 0, w ? "R3 R6 R7 write profile" : "R4 R5 R7 read profile", pe, 0);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7) + (a >> 3) + 8'h5A);
  endfunction

  logic [7:0] rv;
  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(ce_n && oe_n && we_n && !busy && !done, "R1 reset", {ce_n, oe_n, we_n, busy, done}, 5'b11100);
    end
    rst_n = 1;
    @(negedge clk);
    chk(ce_n && oe_n && we_n && !busy && !done, "R1 after reset", {ce_n, oe_n, we_n, busy, done}, 5'b11100);

    xact(1, 11'h000, 8'hFF, 0, rv);
    chk(last_we_low == P, "R2 write pulse cycles", last_we_low, P);
    xact(0, 11'h000, 8'h00, 0, rv);
    chk(last_oe_low == RD, "R2 read access cycles", last_oe_low, RD);
    chk(rv == 8'hFF, "R4 R6 readback 000", rv, 8'hFF);
    xact(1, 11'h7FF, 8'h00, 0, rv);
    xact(0, 11'h7FF, 8'h00, 0, rv);
    chk(rv == 8'h00, "R9 readback 7FF", rv, 8'h00);

    // R8: request injected during a write is dropped
    xact(1, 11'h123, 8'h00, 0, rv);
    xact(1, 11'h6DC, 8'h00, 0, rv);
    xact(1, 11'h123, 8'hA7, 1, rv);
    repeat (20) begin
      @(negedge clk);
      chk(ce_n && !busy, "R8 no extra access", {ce_n, busy}, 2'b10);
    end
    xact(0, 11'h6DC, 8'h00, 0, rv);
    chk(rv == 8'h00, "R8 alternate address untouched", rv, 8'h00);
    xact(0, 11'h123, 8'h00, 1, rv);
    chk(rv == 8'hA7, "R8 target written once", rv, 8'hA7);
    repeat (20) begin
      @(negedge clk);
      chk(ce_n && !busy, "R8 no extra access after read", {ce_n, busy}, 2'b10);
    end

    // R9: full address sweep
    for (int i = 0; i < 2048; i++) xact(1, 11'(i), pat(i), 0, rv);
    for (int i = 0; i < 2048; i++) begin
      xact(0, 11'(i), 8'h00, 0, rv);
      chk(rv == pat(i), "R9 sweep readback", rv, pat(i));
    end
    chk(u_ram.viol == 0, "R3 R5 RAM timing violations", u_ram.viol, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule